// File: doc/BRIEF.md
# Preloadable Up/Down Toggle-Chain Counter

A synchronous binary counter, five bits wide by default, built from identical bit slices. Each slice holds one flip-flop that either toggles or holds on every clock. Its toggle enable comes from one of two ripple chains that run from the least significant slice upward. The up chain is an AND of all lower bits, so a bit toggles when everything below it is one. The down chain is an OR of all lower bits, so a bit toggles when everything below it is zero. A direction input selects which chain drives the toggle enables.

A parallel load input replaces the count with a supplied value on the clock edge. It overrides counting in either direction. A terminal-count flag shows when the counter sits at the end of its range in the selected direction. It can be used with the load to build counts shorter than the full modulus. The chain signals between slices are brought out so that they can be checked directly or used to cascade counters.

Top module: `updn_tgl_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 after that edge.
- R2: With `rst` and `load` low and `dir_up` high, each edge adds one to `count` modulo 2^WIDTH, so 31 goes to 0 at the default width.
- R3: With `rst` and `load` low and `dir_up` low, each edge subtracts one modulo 2^WIDTH, so 0 goes to 31 at the default width.
- R4: With `load` high and `rst` low, the next edge puts `load_val` into `count`, whatever the value of `dir_up`.
- R5: A change on `load`, `load_val` or `dir_up` has no effect on `count` until the next rising edge.
- R6: `term_cnt` is 1 exactly when `dir_up` is 1 and `count` is all ones, or `dir_up` is 0 and `count` is all zeros. It follows `dir_up` with no clock delay.
- R7: `up_chain[i]` is 1 exactly when `count` bits 0 through i are all 1. `dn_chain[i]` is 1 exactly when at least one of `count` bits 0 through i is 1.
- R8: `rst` has priority over `load`. A high `rst` with a high `load` still gives `count` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| load | input | 1 | Parallel load enable, acts on the edge |
| load_val | input | WIDTH | Value to load |
| count | output | WIDTH | Registered count |
| term_cnt | output | 1 | End of range in the selected direction |
| up_chain | output | WIDTH | AND chain after each slice (bit i = bits 0..i all one) |
| dn_chain | output | WIDTH | OR chain after each slice (bit i = any of bits 0..i one) |

## Verification
A wrong slice flip-flop or a broken chain link shows up as a wrong `count` on the first edge that should have toggled that bit. For the top bit, that edge comes only at the half-range crossing, so each direction is run across both wraps. A chain fault can corrupt the toggle enable without any visible effect yet, because the toggle has not been needed. Comparing `up_chain` and `dn_chain` with the count in every cycle exposes such a fault in the same cycle. A load fault appears one edge after `load` rises, and the check just before that edge confirms that nothing moves early.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  parameter int unsigned DEF_WIDTH = 5;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/tgl_slice.sv
module tgl_slice (
  input  logic clk,
  input  logic rst,
  input  logic dir_up,
  input  logic load,
  input  logic load_bit,
  input  logic cup_in,
  input  logic cdn_in,
  output logic q,
  output logic cup_out,
  output logic cdn_out
);
  logic tgl;

  // up: toggle when every lower bit is one; down: when every lower bit is zero
  assign tgl = dir_up ? cup_in : ~cdn_in;

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= load_bit;
    else           q <= q ^ tgl;
  end

  assign cup_out = cup_in & q;
  assign cdn_out = cdn_in | q;
endmodule

// File: rtl/tc_decode.sv
module tc_decode #(
  parameter int unsigned WIDTH = ctr_pkg::DEF_WIDTH
) (
  input  logic             dir_up,
  input  logic [WIDTH-1:0] up_chain,
  input  logic [WIDTH-1:0] dn_chain,
  output logic             term_cnt
);
  import ctr_pkg::*;
  localparam int unsigned MSB = WIDTH - 1;

  // the last chain link already summarises the whole word
  always_comb begin
    case (dir_e'(dir_up))
      DIR_UP:  term_cnt = up_chain[MSB];
      default: term_cnt = ~dn_chain[MSB];
    endcase
  end
endmodule

// File: rtl/updn_tgl_counter.sv
module updn_tgl_counter #(
  parameter int unsigned WIDTH = ctr_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt,
  output logic [WIDTH-1:0] up_chain,
  output logic [WIDTH-1:0] dn_chain
);
  logic [WIDTH:0] cup_link;
  logic [WIDTH:0] cdn_link;

  // bit 0 always toggles while counting
  assign cup_link[0] = 1'b1;
  assign cdn_link[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    tgl_slice u_slice (
      .clk      (clk),
      .rst      (rst),
      .dir_up   (dir_up),
      .load     (load),
      .load_bit (load_val[i]),
      .cup_in   (cup_link[i]),
      .cdn_in   (cdn_link[i]),
      .q        (count[i]),
      .cup_out  (cup_link[i+1]),
      .cdn_out  (cdn_link[i+1])
    );
  end

  assign up_chain = cup_link[WIDTH:1];
  assign dn_chain = cdn_link[WIDTH:1];

  tc_decode #(.WIDTH(WIDTH)) u_tc (
    .dir_up   (dir_up),
    .up_chain (up_chain),
    .dn_chain (dn_chain),
    .term_cnt (term_cnt)
  );
endmodule

// File: rtl/updn_tgl_counter_chk.sv
module updn_tgl_counter_chk #(
  parameter int unsigned WIDTH = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dir_up,
  input logic             load,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic             term_cnt,
  input logic [WIDTH-1:0] up_chain,
  input logic [WIDTH-1:0] dn_chain
);
  // R1 and R8: reset wins, load ignored
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> count == '0);

  // R2
  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && dir_up) |=> count == WIDTH'($past(count) + 1'b1));

  // R3
  p_dn_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !dir_up) |=> count == WIDTH'($past(count) - 1'b1));

  // R4
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));

  // R6: flag consistent with the count word
  p_tc_up_r6: assert property (@(posedge clk) disable iff (rst)
    (term_cnt && dir_up) |-> (&count));
  p_tc_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (term_cnt && !dir_up) |-> (count == '0));

  // R7: chains are thermometer-shaped
  p_chain_shape_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(up_chain ^ (up_chain >> 1)) <= 1 &&
    $countones(dn_chain ^ (dn_chain << 1)) <= 1);
endmodule

bind updn_tgl_counter updn_tgl_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_updn_tgl_counter.sv
module tb_updn_tgl_counter;
  localparam int unsigned W = 5;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         dir_up;
  logic         load;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic         term_cnt;
  logic [W-1:0] up_chain;
  logic [W-1:0] dn_chain;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  updn_tgl_counter #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .load(load), .load_val(load_val),
    .count(count), .term_cnt(term_cnt), .up_chain(up_chain), .dn_chain(dn_chain)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 and R7 checked against the bench's own expected count
  task automatic chk_side(int c, logic d);
    int eu = 0;
    int ed = 0;
    int et;
    for (int i = 0; i < int'(W); i++) begin
      bit all1 = 1'b1;
      bit any1 = 1'b0;
      for (int j = 0; j <= i; j++) begin
        all1 = all1 & c[j];
        any1 = any1 | c[j];
      end
      eu |= int'(all1) << i;
      ed |= int'(any1) << i;
    end
    et = d ? int'(c == MOD - 1) : int'(c == 0);
    chk("R6 term_cnt", int'(term_cnt), et);
    chk("R7 up_chain", int'(up_chain), eu);
    chk("R7 dn_chain", int'(dn_chain), ed);
  endtask

  task automatic t_reset();
    rst = 1'b1; load = 1'b0; dir_up = 1'b0; load_val = '0;
    tick(); tick();
    exp_cnt = 0;
    chk("R1 count after reset", int'(count), 0);
    chk_side(exp_cnt, dir_up);
    rst = 1'b0;
  endtask

  task automatic t_count_up();
    dir_up = 1'b1;
    for (int k = 0; k < 40; k++) begin
      tick();
      exp_cnt = (exp_cnt + 1) % MOD;
      chk("R2 count up", int'(count), exp_cnt);
      chk_side(exp_cnt, dir_up);
    end
  endtask

  task automatic t_count_down();
    dir_up = 1'b0;
    for (int k = 0; k < 45; k++) begin
      tick();
      exp_cnt = (exp_cnt + MOD - 1) % MOD;
      chk("R3 count down", int'(count), exp_cnt);
      chk_side(exp_cnt, dir_up);
    end
  endtask

  task automatic t_load();
    dir_up = 1'b1; load = 1'b1; load_val = 5'd13;
    #1;
    chk("R5 no early load", int'(count), exp_cnt);
    tick();
    exp_cnt = 13;
    chk("R4 load while up", int'(count), 13);
    dir_up = 1'b0; load_val = 5'd31;
    tick();
    exp_cnt = 31;
    chk("R4 load while down", int'(count), 31);
    chk_side(exp_cnt, dir_up);
    tick();
    chk("R4 load held", int'(count), 31);
    load = 1'b0;
    tick();
    exp_cnt = 30;
    chk("R3 after load", int'(count), 30);
  endtask

  task automatic t_dir_change();
    dir_up = 1'b1;
    #1;
    chk("R5 dir change no early move", int'(count), exp_cnt);
    chk_side(exp_cnt, dir_up);
    tick();
    exp_cnt = (exp_cnt + 1) % MOD;
    chk("R2 after dir change", int'(count), exp_cnt);
    load = 1'b1; load_val = 5'd0;
    tick();
    load = 1'b0; dir_up = 1'b0;
    exp_cnt = 0;
    #1;
    chk_side(exp_cnt, dir_up);
    dir_up = 1'b1;
    #1;
    chk_side(exp_cnt, dir_up);
  endtask

  task automatic t_reset_over_load();
    load = 1'b1; load_val = 5'd21; rst = 1'b1;
    tick();
    exp_cnt = 0;
    chk("R8 reset beats load", int'(count), 0);
    rst = 1'b0; load = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count_up();
    t_count_down();
    t_load();
    t_dir_change();
    t_reset_over_load();
    t_count_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule